// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits on a host I/O bus and turns the classic two-port configuration mechanism into configuration requests. Software first writes a 32-bit word into an address latch through one I/O port, then reads or writes one to four bytes through a four-port data window. The latched word selects a bus, a device/function and a dword register. The low two bits of the data port number give the byte offset within that register.

Requests for bus 0 go to the local functions over a request interface. The local functions answer with a presence flag and read data in the same cycle. Requests for any other bus are forwarded to the first bridge whose secondary-to-subordinate bus range covers the target bus. A request that no one can take is resolved here: reads return all ones and writes are dropped. The whole exchange completes in the cycle of the I/O access. Only the address latch is a register.

Top module: `cfgp_top`

## Requirements
- R1: A write to the address port (default 0xCF8) with size code 2 (4 bytes) loads the full 32-bit word into the address latch on the next clock edge. Address-port writes with any other size code leave the latch unchanged.
- R2: A read of the address port with size code 2 returns the latch with io_hit=1. Any other size at that port gives io_hit=0 and io_rdata=0xFFFFFFFF.
- R3: While latch bit 31 (enable) is 0, data-window accesses are claimed (io_hit=1) but raise neither cfg_valid nor fwd_valid, and reads return 0xFFFFFFFF.
- R4: With enable set and latch bits 23:16 (bus) equal to 0, a data-window access at port DATA_PORT+k raises cfg_valid in the same cycle. It presents req_devfn = latch bits 15:8 and req_reg = {latch bits 7:2, k}, along with req_size, req_write and req_wdata.
- R5: A local read whose target reports cfg_present=0 returns 0xFFFFFFFF.
- R6: Read data from a present or forwarded target is returned right-aligned and masked to the access size: code 0 keeps bits 7:0, code 1 keeps bits 15:0, code 2 keeps all 32 bits.
- R7: With enable set and a nonzero bus, the request goes to the lowest-index bridge b with br_sec[b] <= bus <= br_sub[b]. It raises fwd_valid with fwd_sel one-hot at b and fwd_bus equal to the bus, and the read returns the masked fwd_rdata.
- R8: With enable set, a nonzero bus and no bridge range covering it, no request is raised and reads return 0xFFFFFFFF.
- R9: Size code 3, or a port outside the address port and the four data ports, is not claimed: io_hit=0, no request is raised, and io_rdata=0xFFFFFFFF.
- R10: After reset the address latch reads 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_valid | input | 1 | I/O access present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | PORT_W | I/O port number |
| io_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| io_wdata | input | 32 | Write data, right-aligned |
| io_rdata | output | 32 | Read data, right-aligned |
| io_hit | output | 1 | The access is claimed by this block |
| req_write | output | 1 | Request direction (shared by both request paths) |
| req_devfn | output | 8 | Target device/function |
| req_reg | output | 8 | Target register byte address |
| req_size | output | 2 | Request size code |
| req_wdata | output | 32 | Request write data |
| cfg_valid | output | 1 | Request toward local bus-0 functions |
| cfg_present | input | 1 | Addressed local function exists |
| cfg_rdata | input | 32 | Local read data |
| fwd_valid | output | 1 | Request toward a downstream bridge |
| fwd_sel | output | NUM_BRIDGES | One-hot selected bridge |
| fwd_bus | output | 8 | Target bus number |
| fwd_rdata | input | 32 | Read data from the selected bridge |
| br_sec | input | NUM_BRIDGES*8 | Secondary bus number per bridge |
| br_sub | input | NUM_BRIDGES*8 | Subordinate bus number per bridge |

## Verification
The bench builds the block with the default ports and NUM_BRIDGES=2, with overlapping bridge ranges 1..3 and 2..5. The overlap puts the lowest-index priority within reach (buses 2 and 3), and bus 4 reaches only the second bridge. Buses 6 and up exercise the no-bridge drop. The bench's local function model reports devices 0 to 3 present and the rest absent, so both the present and the all-ones outcome occur on bus 0. Random latch words, sizes and ports, including the reserved size and neighbouring unclaimed ports, are mixed with directed cases.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam int BUS_W  = 8;
   localparam int DFN_W  = 8;
   localparam int DATA_W = 32;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_RSVD  = 2'd3
   } io_size_e;

   function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_mask = 32'h0000_00FF;
         SZ_WORD: size_mask = 32'h0000_FFFF;
         default: size_mask = 32'hFFFF_FFFF;
      endcase
   endfunction
endpackage

// File: rtl/cfgp_port_decode.sv
module cfgp_port_decode
   import cfgp_pkg::*;
#(
   parameter int              PORT_W    = 16,
   parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
   parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC
) (
   input  logic              io_valid,
   input  logic [PORT_W-1:0] io_port,
   input  logic [1:0]        io_size,
   output logic              addr_sel,
   output logic              data_sel,
   output logic [1:0]        byte_off
);
   logic size_ok;
   assign size_ok  = (io_size != SZ_RSVD);
   assign addr_sel = io_valid && (io_port == ADDR_PORT) && (io_size == SZ_DWORD);
   assign data_sel = io_valid && size_ok
                     && (io_port[PORT_W-1:2] == DATA_PORT[PORT_W-1:2]);
   assign byte_off = io_port[1:0];
endmodule

// File: rtl/cfgp_addr_latch.sv
module cfgp_addr_latch
   import cfgp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] ld_data,
   output logic [DATA_W-1:0] latch_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     latch_q <= '0;
      else if (ld_en) latch_q <= ld_data;
   end

   // R1
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (latch_q == $past(ld_data)));
endmodule

// File: rtl/cfgp_bridge_match.sv
module cfgp_bridge_match
   import cfgp_pkg::*;
#(
   parameter int NUM_BRIDGES = 2
) (
   input  logic [BUS_W-1:0]             bus,
   input  logic [NUM_BRIDGES*BUS_W-1:0] sec,
   input  logic [NUM_BRIDGES*BUS_W-1:0] sub,
   output logic [NUM_BRIDGES-1:0]       sel,
   output logic                         any
);
   logic [NUM_BRIDGES-1:0] in_rng;

   for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_rng
      assign in_rng[b] = (bus >= sec[b*BUS_W +: BUS_W]) &&
                         (bus <= sub[b*BUS_W +: BUS_W]);
   end

   // lowest index wins: scan downward, the last hit overwrites
   always_comb begin
      sel = '0;
      for (int b = NUM_BRIDGES - 1; b >= 0; b--) begin
         if (in_rng[b]) begin
            sel    = '0;
            sel[b] = 1'b1;
         end
      end
   end

   assign any = |in_rng;
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
   import cfgp_pkg::*;
#(
   parameter int              PORT_W      = 16,
   parameter logic [PORT_W-1:0] ADDR_PORT   = 16'hCF8,
   parameter logic [PORT_W-1:0] DATA_PORT   = 16'hCFC,
   parameter int              NUM_BRIDGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         io_valid,
   input  logic                         io_write,
   input  logic [PORT_W-1:0]            io_port,
   input  logic [1:0]                   io_size,
   input  logic [31:0]                  io_wdata,
   output logic [31:0]                  io_rdata,
   output logic                         io_hit,
   output logic                         req_write,
   output logic [7:0]                   req_devfn,
   output logic [7:0]                   req_reg,
   output logic [1:0]                   req_size,
   output logic [31:0]                  req_wdata,
   output logic                         cfg_valid,
   input  logic                         cfg_present,
   input  logic [31:0]                  cfg_rdata,
   output logic                         fwd_valid,
   output logic [NUM_BRIDGES-1:0]       fwd_sel,
   output logic [7:0]                   fwd_bus,
   input  logic [31:0]                  fwd_rdata,
   input  logic [NUM_BRIDGES*8-1:0]     br_sec,
   input  logic [NUM_BRIDGES*8-1:0]     br_sub
);
   localparam int EN_BIT  = DATA_W - 1;
   localparam int BUS_LSB = 16;
   localparam int DFN_LSB = 8;

   if (NUM_BRIDGES < 1) begin : g_bad_nb
      $error("cfgp_top: NUM_BRIDGES must be at least 1");
   end
   if (PORT_W < 3) begin : g_bad_pw
      $error("cfgp_top: PORT_W too narrow");
   end
   if (DATA_PORT[1:0] != 2'b00) begin : g_bad_dp
      $error("cfgp_top: DATA_PORT must be dword aligned");
   end

   logic              addr_sel, data_sel, latch_wr;
   logic [1:0]        byte_off;
   logic [DATA_W-1:0] latch_q;
   logic              en;
   logic [BUS_W-1:0]  bus;
   logic [NUM_BRIDGES-1:0] match_sel;
   logic              match_any, routed;
   logic [DATA_W-1:0] mask;

   cfgp_port_decode #(
      .PORT_W(PORT_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
   ) dec_i (
      .io_valid(io_valid), .io_port(io_port), .io_size(io_size),
      .addr_sel(addr_sel), .data_sel(data_sel), .byte_off(byte_off)
   );

   assign latch_wr = addr_sel && io_write;

   cfgp_addr_latch latch_i (
      .clk(clk), .rst_n(rst_n), .ld_en(latch_wr),
      .ld_data(io_wdata), .latch_q(latch_q)
   );

   assign en  = latch_q[EN_BIT];
   assign bus = latch_q[BUS_LSB +: BUS_W];

   cfgp_bridge_match #(.NUM_BRIDGES(NUM_BRIDGES)) match_i (
      .bus(bus), .sec(br_sec), .sub(br_sub),
      .sel(match_sel), .any(match_any)
   );

   assign routed    = data_sel && en;
   assign cfg_valid = routed && (bus == '0);
   assign fwd_valid = routed && (bus != '0) && match_any;
   assign fwd_sel   = fwd_valid ? match_sel : '0;
   assign fwd_bus   = bus;

   assign req_write = io_write;
   assign req_devfn = latch_q[DFN_LSB +: DFN_W];
   assign req_reg   = {latch_q[7:2], byte_off};
   assign req_size  = io_size;
   assign req_wdata = io_wdata;

   assign io_hit = addr_sel || data_sel;
   assign mask   = size_mask(io_size);

   always_comb begin
      if (addr_sel)                       io_rdata = latch_q;
      else if (cfg_valid && cfg_present)  io_rdata = cfg_rdata & mask;
      else if (fwd_valid)                 io_rdata = fwd_rdata & mask;
      else                                io_rdata = '1;
   end

   // R1
   addr_narrow_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_valid && io_write && io_port == ADDR_PORT && io_size != SZ_DWORD)
      |=> $stable(latch_q));

   // R3
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_q[EN_BIT] |-> !(cfg_valid || fwd_valid));

   // R4
   single_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_valid && fwd_valid));

   // R7
   fwd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fwd_sel) && (fwd_valid == (fwd_sel != '0)));

   // R9
   reserved_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_size == SZ_RSVD) |-> !(io_hit || cfg_valid || fwd_valid));
endmodule

// File: tb/cfgp_top_tb_top.sv
`timescale 1ns/1ps
module cfgp_top_tb_top;
   localparam int NB = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_valid = 1'b0, io_write = 1'b0;
   logic [15:0] io_port = 16'h0;
   logic [1:0]  io_size = 2'd0;
   logic [31:0] io_wdata = 32'h0;
   logic [31:0] io_rdata;
   logic        io_hit, req_write, cfg_valid, fwd_valid, cfg_present;
   logic [7:0]  req_devfn, req_reg, fwd_bus;
   logic [1:0]  req_size;
   logic [31:0] req_wdata, cfg_rdata, fwd_rdata;
   logic [NB-1:0] fwd_sel;
   logic [NB*8-1:0] br_sec, br_sub;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [31:0] m_latch;

   always #2.5 clk = ~clk;

   assign br_sec = {8'd2, 8'd1};
   assign br_sub = {8'd5, 8'd3};

   // local function and bridge models (targets, not the decoder)
   always_comb begin
      cfg_present = (req_devfn[7:3] < 5'd4);
      cfg_rdata   = {req_devfn, req_reg, 16'hC0DE};
      fwd_rdata   = {fwd_bus, req_devfn, req_reg, 8'h5A};
   end

   cfgp_top #(.NUM_BRIDGES(NB)) dut_i (
      .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
      .io_port(io_port), .io_size(io_size), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_hit(io_hit), .req_write(req_write),
      .req_devfn(req_devfn), .req_reg(req_reg), .req_size(req_size),
      .req_wdata(req_wdata), .cfg_valid(cfg_valid), .cfg_present(cfg_present),
      .cfg_rdata(cfg_rdata), .fwd_valid(fwd_valid), .fwd_sel(fwd_sel),
      .fwd_bus(fwd_bus), .fwd_rdata(fwd_rdata), .br_sec(br_sec), .br_sub(br_sub)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mask_of(input logic [1:0] sz);
      return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   // one access: drive after an edge, check mid-cycle, update model at next edge
   task automatic acc(input bit w, input logic [15:0] port, input logic [1:0] sz,
                      input logic [31:0] wd);
      bit is_addr, is_data, en, e_cfg, e_fwd, e_hit;
      logic [7:0] bus, devfn, rg;
      logic [NB-1:0] e_sel;
      logic [31:0] e_rd;
      string tag;
      @(posedge clk); #1;
      io_valid = 1'b1; io_write = w; io_port = port; io_size = sz; io_wdata = wd;
      #2;
      is_addr = (port == 16'hCF8) && (sz == 2'd2);
      is_data = (port[15:2] == 14'h33F) && (sz != 2'd3);
      en = m_latch[31]; bus = m_latch[23:16]; devfn = m_latch[15:8];
      rg = {m_latch[7:2], port[1:0]};
      e_sel = '0;
      if (bus >= 8'd1 && bus <= 8'd3) e_sel = 2'b01;
      else if (bus >= 8'd2 && bus <= 8'd5) e_sel = 2'b10;
      e_cfg = is_data && en && bus == 0;
      e_fwd = is_data && en && bus != 0 && e_sel != 0;
      if (!e_fwd) e_sel = '0;
      e_hit = is_addr || is_data;
      if (port == 16'hCF8 && !is_addr) tag = (w ? "R1" : "R2");
      else if (!e_hit) tag = "R9";
      else if (is_addr) tag = (w ? "R1" : "R2");
      else if (!en) tag = "R3";
      else if (bus == 0) tag = (devfn[7:3] < 5'd4) ? "R6" : "R5";
      else tag = (e_sel != 0) ? "R7" : "R8";
      if (tag == "R6" && w) tag = "R4";
      if (is_addr) e_rd = m_latch;
      else if (e_cfg && devfn[7:3] < 5'd4) e_rd = {devfn, rg, 16'hC0DE} & mask_of(sz);
      else if (e_fwd) e_rd = {bus, devfn, rg, 8'h5A} & mask_of(sz);
      else e_rd = 32'hFFFF_FFFF;
      chk(tag, "io_hit", {31'b0, io_hit}, {31'b0, e_hit});
      chk(tag, "cfg_valid", {31'b0, cfg_valid}, {31'b0, e_cfg});
      chk(tag, "fwd_valid/sel", {29'b0, fwd_valid, fwd_sel}, {29'b0, e_fwd, e_sel});
      if (!w) chk(tag, "io_rdata", io_rdata, e_rd);
      if (e_cfg || e_fwd) begin
         chk(tag, "req devfn/reg/size/write",
             {13'b0, req_write, req_size, req_devfn, req_reg},
             {13'b0, w, sz, devfn, rg});
         if (w) chk(tag, "req_wdata", req_wdata, wd);
         if (e_fwd) chk(tag, "fwd_bus", {24'b0, fwd_bus}, {24'b0, bus});
      end
      @(posedge clk);
      if (w && is_addr) m_latch = wd;
      #1 io_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] seed_dummy;
      seed_dummy = $urandom(32'd4242);
      m_latch = 32'h0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R10 reset value via address port read
      acc(0, 16'hCF8, 2'd2, 0);
      // R1 full write loads, narrow writes ignored
      acc(1, 16'hCF8, 2'd2, 32'h8000_0A08);
      acc(0, 16'hCF8, 2'd2, 0);
      acc(1, 16'hCF8, 2'd1, 32'h0000_1234);
      acc(1, 16'hCF8, 2'd0, 32'h0000_00EE);
      acc(0, 16'hCF8, 2'd2, 0);
      // R2 narrow address read unclaimed
      acc(0, 16'hCF8, 2'd1, 0);
      // R3 enable clear
      acc(1, 16'hCF8, 2'd2, 32'h0000_0810);
      acc(0, 16'hCFC, 2'd2, 0);
      acc(1, 16'hCFD, 2'd0, 32'h77);
      // R4 / R6 local present device 1
      acc(1, 16'hCF8, 2'd2, 32'h8000_0810);
      acc(1, 16'hCFC, 2'd2, 32'hDEAD_BEEF);
      acc(0, 16'hCFE, 2'd1, 0);
      acc(0, 16'hCFF, 2'd0, 0);
      acc(0, 16'hCFC, 2'd2, 0);
      // R5 absent device 31
      acc(1, 16'hCF8, 2'd2, 32'h8000_F800);
      acc(0, 16'hCFC, 2'd2, 0);
      // R7 priority and second bridge
      acc(1, 16'hCF8, 2'd2, 32'h8002_1004);
      acc(0, 16'hCFD, 2'd0, 0);
      acc(1, 16'hCF8, 2'd2, 32'h8004_2000);
      acc(1, 16'hCFE, 2'd1, 32'h0000_5555);
      acc(0, 16'hCFC, 2'd2, 0);
      // R8 no bridge covers bus 6
      acc(1, 16'hCF8, 2'd2, 32'h8006_0000);
      acc(0, 16'hCFC, 2'd2, 0);
      acc(1, 16'hCFC, 2'd2, 32'h1);
      // R9 reserved size and neighbouring ports
      acc(1, 16'hCF8, 2'd2, 32'h8000_0800);
      acc(0, 16'hCFC, 2'd3, 0);
      acc(0, 16'hCF9, 2'd0, 0);
      acc(0, 16'hD00, 2'd2, 0);
      // random mix
      for (int i = 0; i < 400; i++) begin
         int unsigned pick;
         logic [15:0] p;
         pick = $urandom % 10;
         if (pick < 3) begin
            acc(1, 16'hCF8, 2'd2, {$urandom_range(1, 0) == 1, 7'h0,
                8'($urandom % 8), 8'($urandom), 8'($urandom)});
         end else begin
            case ($urandom % 8)
               0: p = 16'hCF8;
               1: p = 16'hCF9;
               2: p = 16'h0080;
               default: p = 16'hCFC + 16'($urandom % 4);
            endcase
            acc(pick[0], p, 2'($urandom % 4), $urandom);
         end
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule